// File: doc/BRIEF.md
# Multi-Mode Timer Base with Prescaler

This block is the shared time base for a set of capture/compare channels. A 16-bit count register advances on a clock-enable pulse. That pulse is chosen from four incoming tick inputs and then divided by 1, 2, 4 or 8. Software picks one of four counting behaviours: halted, counting up to a programmable limit, running freely through the full range, or counting up to the limit and back down again. The limit sits in its own register.

A self-clearing clear bit returns the count, the divider and the up/down direction to their start values. A wrap flag is raised whenever ordinary counting brings the count back to zero. When its enable bit is set, the flag drives the interrupt output. The count is presented on a port so that channel logic can compare against it or capture it. Software reaches the block through a small write port and a read port with a combinational read mux.

Top module: `tmr_base`

## Requirements
- R1: After reset the count is 0, the mode is halted, the divider, source, enable and flag fields are 0, and `irq` is low.
- R2: In mode 0 (control bits [1:0] = 0) the count and the divider phase do not change. Selecting a counting mode again continues from the held count.
- R3: In mode 1 each divided tick advances the count by one until it equals the limit. The next tick returns it to 0, so the period is limit+1. A count above the limit also returns to 0. A limit of 0 keeps the count at 0.
- R4: In mode 2 each divided tick adds one, and 0xFFFF is followed by 0x0000.
- R5: In mode 3 the count rises to the limit and then falls to 0, so a limit of 3 gives 0,1,2,3,2,1,0,1 and the period is 2×limit. The direction turns on the tick taken at the limit while rising, and on the tick taken at 0 while falling. A limit of 0 keeps the count at 0.
- R6: Control bits [5:4] pick which bit of `tick_src` drives the count. Ticks on the other bits have no effect on the count.
- R7: Control bits [3:2] = n make the count advance on every 2^n-th selected tick. The divider phase advances on every selected tick while the mode is not 0.
- R8: A control write with bit 6 set zeroes the count and the divider phase and sets the direction to rising. Bit 6 always reads back 0.
- R9: The wrap flag (control bit 8) is set when a counting step takes a nonzero count to 0. It is never set by a count write or by a clear. `irq` equals the flag ANDed with control bit 7. A control write loads bit 8 into the flag unless a wrap occurs in the same cycle.
- R10: The write and read address selects the control register at 0, the limit at 1 and the count at 2. Address 3 reads as 0. Writes take effect at the next clock edge, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 16 | Read data |
| tick_src | input | 4 | Four clock-enable tick inputs |
| count | output | 16 | Current count value |
| irq | output | 1 | Wrap interrupt request |

## Verification
Two cases are hard to reach by counting alone: the free-running wrap from 0xFFFF to 0, and a wrap that coincides with a clear or a count write. Counting up from zero would take 65536 divided ticks. The bench instead preloads the count through the count write address to just below the top, and then lets the random phase scatter count writes and clears among active ticks. Every cycle is compared against a bench model, so wraps that meet a write in the same cycle are exercised and checked.

// File: rtl/tmr_base.sv
module tmr_base #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic [3:0]   tick_src,
  output logic [W-1:0] count,
  output logic         irq
);
  logic [1:0]   mode, div, src;
  logic         ie, flag, dir_dn, ndn;
  logic [2:0]   pre;
  logic [W-1:0] cnt, modv, nxt;

  wire wr_ctl  = wr_en && (wr_addr == 2'd0);
  wire wr_mod  = wr_en && (wr_addr == 2'd1);
  wire wr_cnt  = wr_en && (wr_addr == 2'd2);
  wire clr     = wr_ctl && wr_data[6];
  wire run     = (mode != 2'd0);
  wire tick_in = tick_src[src];
  wire [2:0] mask = 3'b111 >> (2'd3 - div);
  wire adv     = run && tick_in && ((pre & mask) == mask);
  wire wrap    = adv && (nxt == '0) && (cnt != '0) && !clr && !wr_cnt;

  always_comb begin
    nxt = cnt;
    ndn = dir_dn;
    case (mode)
      2'd1: nxt = (cnt >= modv) ? '0 : cnt + W'(1);
      2'd2: nxt = cnt + W'(1);
      2'd3: begin
        if (modv == '0) nxt = '0;
        else if (!dir_dn) begin
          if (cnt >= modv) begin ndn = 1'b1; nxt = cnt - W'(1); end
          else nxt = cnt + W'(1);
        end else begin
          if (cnt == '0) begin ndn = 1'b0; nxt = W'(1); end
          else nxt = cnt - W'(1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; dir_dn <= 1'b0; pre <= '0;
      mode <= '0; div <= '0; src <= '0; ie <= 1'b0; flag <= 1'b0;
      modv <= '0;
    end else begin
      if (clr) begin
        cnt <= '0; dir_dn <= 1'b0;
      end else if (wr_cnt) begin
        cnt <= wr_data;
      end else if (adv) begin
        cnt <= nxt; dir_dn <= ndn;
      end

      if (clr) pre <= '0;
      else if (run && tick_in) pre <= pre + 3'd1;

      if (wr_ctl) begin
        mode <= wr_data[1:0];
        div  <= wr_data[3:2];
        src  <= wr_data[5:4];
        ie   <= wr_data[7];
      end

      if (wrap) flag <= 1'b1;
      else if (wr_ctl) flag <= wr_data[8];

      if (wr_mod) modv <= wr_data;
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {{(W-9){1'b0}}, flag, ie, 1'b0, src, div, mode};
      2'd1:    rd_data = modv;
      2'd2:    rd_data = cnt;
      default: rd_data = '0;
    endcase
  end

  assign count = cnt;
  assign irq   = flag & ie;
endmodule

module tmr_base_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic [1:0]   mode,
  input logic [W-1:0] count,
  input logic [W-1:0] modv,
  input logic         flag
);
  a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !wr_en) |=> $stable(count));

  a_r3_up_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !wr_en && count <= modv) |=> (count <= modv));

  a_r4_free_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !wr_en) |=>
      (count == $past(count) || count == $past(count) + W'(1)));

  a_r5_updown_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !wr_en && count <= modv) |=>
      (count <= modv && (count == $past(count) || count == $past(count) + W'(1)
                         || count == $past(count) - W'(1))));

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && wr_data[6]) |=> (count == '0));

  a_r9_clear_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && wr_data[6] && !wr_data[8]) |=> !flag);
endmodule

bind tmr_base tmr_base_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .mode(mode), .count(cnt), .modv(modv), .flag(flag)
);

// File: tb/tb_tmr_base.sv
`timescale 1ns/1ps
module tb_tmr_base;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [3:0]  tick_src = '0;
  logic [15:0] count;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_tag = "R1";

  tmr_base dut (.*);

  always #4 clk = ~clk;

  // bench model state
  logic [1:0]  m_mode, m_div, m_src;
  logic        m_ie, m_flag, m_dn;
  logic [2:0]  m_pre;
  logic [15:0] m_cnt, m_mod;

  function automatic logic [15:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {7'd0, m_flag, m_ie, 1'b0, m_src, m_div, m_mode};
      2'd1: return m_mod;
      2'd2: return m_cnt;
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_div = 0; m_src = 0; m_ie = 0; m_flag = 0; m_dn = 0;
      m_pre = 0; m_cnt = 0; m_mod = 0;
    end else begin
      logic active, step, clr, wcnt, wctl, ndn, wr;
      logic [15:0] nc;
      int period;
      period = 1 << m_div;
      active = (m_mode != 0) && tick_src[m_src];
      step = active && ((int'(m_pre) % period) == period - 1);
      wctl = wr_en && wr_addr == 0;
      clr  = wctl && wr_data[6];
      wcnt = wr_en && wr_addr == 2;
      nc = m_cnt; ndn = m_dn;
      if (m_mode == 1) nc = (m_cnt >= m_mod) ? 16'd0 : m_cnt + 16'd1;
      else if (m_mode == 2) nc = m_cnt + 16'd1;
      else if (m_mode == 3) begin
        if (m_mod == 0) nc = 0;
        else if (!m_dn) begin
          if (m_cnt >= m_mod) begin ndn = 1; nc = m_cnt - 16'd1; end
          else nc = m_cnt + 16'd1;
        end else if (m_cnt == 0) begin ndn = 0; nc = 16'd1; end
        else nc = m_cnt - 16'd1;
      end
      wr = step && nc == 0 && m_cnt != 0 && !clr && !wcnt;
      if (clr) begin m_cnt = 0; m_dn = 0; end
      else if (wcnt) m_cnt = wr_data;
      else if (step) begin m_cnt = nc; m_dn = ndn; end
      if (clr) m_pre = 0; else if (active) m_pre = m_pre + 3'd1;
      if (wr) m_flag = 1;
      else if (wctl) m_flag = wr_data[8];
      if (wctl) begin
        m_mode = wr_data[1:0]; m_div = wr_data[3:2]; m_src = wr_data[5:4]; m_ie = wr_data[7];
      end
      if (wr_en && wr_addr == 1) m_mod = wr_data;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check(count === m_cnt, cur_tag, "count", count, m_cnt);
    check(irq === (m_flag & m_ie), "R9", "irq", {15'd0, irq}, {15'd0, m_flag & m_ie});
    check(rd_data === exp_rd(rd_addr), "R10", "rd_data", rd_data, exp_rd(rd_addr));
  endtask

  task automatic cyc(input logic we, input logic [1:0] wa, input logic [15:0] wd,
                     input logic [3:0] tk, input logic [1:0] ra);
    @(negedge clk);
    compare();
    wr_en = we; wr_addr = wa; wr_data = wd; tick_src = tk; rd_addr = ra;
  endtask

  task automatic run(input int n, input logic [3:0] tk);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, tk, 2'(i));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R1";
    cyc(0, 0, 0, 4'hF, 0);
    cyc(0, 0, 0, 4'hF, 2);
    check(count == 0 && irq == 0, "R1", "reset count/irq", count, 0);

    cur_tag = "R3";
    cyc(1, 1, 16'd4, 4'h1, 1);
    cyc(1, 0, 16'h00C1, 4'h1, 0);
    run(14, 4'h1);

    cur_tag = "R2";
    cyc(1, 0, 16'h0080, 4'h1, 0);
    run(6, 4'h1);
    cyc(1, 0, 16'h0081, 4'h1, 0);
    run(4, 4'h1);

    cur_tag = "R4";
    cyc(1, 0, 16'h0082, 4'h1, 0);
    cyc(1, 2, 16'hFFFA, 4'h1, 2);
    run(10, 4'h1);

    cur_tag = "R9";
    cyc(1, 0, 16'h0082, 4'h1, 0);
    cyc(1, 2, 16'h0000, 4'h1, 0);
    cyc(1, 2, 16'hFFFF, 4'h0, 2);
    cyc(1, 0, 16'h00C2, 4'h1, 0);
    run(3, 4'h1);
    cur_tag = "R8";
    cyc(1, 0, 16'h00C3, 4'h1, 0);
    run(4, 4'h1);

    cur_tag = "R5";
    cyc(1, 1, 16'd3, 4'h1, 1);
    cyc(1, 0, 16'h00C3, 4'h1, 0);
    run(16, 4'h1);
    cyc(1, 1, 16'd0, 4'h1, 1);
    run(5, 4'h1);

    cur_tag = "R6";
    cyc(1, 0, 16'h00E2, 4'h1, 0);
    run(6, 4'b1011);
    run(6, 4'b0100);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 4'($urandom), 2);

    cur_tag = "R7";
    for (int d = 0; d < 4; d++) begin
      cyc(1, 0, 16'h0042 | 16'(d << 2), 4'hF, 0);
      run(24, 4'hF);
    end

    for (int i = 0; i < 4000; i++) begin
      logic we; logic [1:0] wa; logic [15:0] wd; int r;
      case (m_mode)
        0: cur_tag = "R2";
        1: cur_tag = "R3";
        2: cur_tag = "R4";
        default: cur_tag = "R5";
      endcase
      we = ($urandom % 12) == 0;
      wa = 2'($urandom % 3);
      r = $urandom % 4;
      if (wa == 1) wd = 16'($urandom % 9);
      else if (wa == 2) wd = (r == 0) ? 16'hFFFD : 16'($urandom % 10);
      else wd = {7'd0, 1'($urandom), 1'($urandom), (r == 0), 2'($urandom), 2'($urandom),
                 (r == 3) ? 2'd0 : 2'($urandom)};
      cyc(we, wa, wd, 4'($urandom), 2'($urandom));
    end
    cyc(0, 0, 0, 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule